// File: doc/BRIEF.md
# Vector Compare to Predicate Mask

This unit reinterprets a conditional-branch operation as an element-by-element comparison loop. It is given two source base registers, a flag for each saying whether that source is vectorised, a comparison code, a vector length and a target predicate register. For every element index it fetches one operand pair through a two-port register-read interface and compares them. Each element that satisfies the comparison sets the matching bit of a mask. The mask is merged by OR into the prior contents of the target register and written back once with a single write strobe.

When neither source is vectorised, the unit runs no loop and raises a one-cycle branch indication instead, so the surrounding pipeline can take an ordinary branch. Branch target arithmetic and the register storage itself lie outside the unit.

The controller is a five-state machine:
- `ST_IDLE`: waits for a start.
- `ST_MASK_RD`: reads the prior predicate value.
- `ST_ELEM_RD`: issues one element read per cycle.
- `ST_FLUSH`: consumes the last read response.
- `ST_WRITE`: drives the write strobe.

The transitions are:
- IDLE→MASK_RD on an accepted start with at least one vectorised source.
- MASK_RD→FLUSH when the length is zero, otherwise MASK_RD→ELEM_RD.
- ELEM_RD→ELEM_RD until the last index, then ELEM_RD→FLUSH.
- FLUSH→WRITE.
- WRITE→IDLE.

An accepted start with two scalar sources leaves the machine in IDLE and only pulses the branch output.

Top module: `vcmp_mask_unit`

## Requirements
- R1: A start accepted in idle with both vectorised flags low raises `branch_o` for exactly the next cycle. It causes no register read, no write, and leaves `busy_o` low.
- R2: For element index i, a vectorised source reads register (base + i) modulo 32, and a scalar source reads its base register. Port A carries the first source and port B the second.
- R3: Comparison codes on `cmp_op_i` are: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal, with the first source on the left of the relation. Codes 010 and 011 never hold.
- R4: The prior value of the target register is read through port A before any element. Bit i of the written value is the OR of the prior bit i and the comparison result for element i.
- R5: Bits at index vector-length and above keep their prior value. A length above 32 is treated as 32. A length of zero writes the prior value unchanged.
- R6: Elements are compared at one per cycle. The single-cycle write strobe `wr_en_o` is high, addressed to the target register, in the (L+3)-th cycle after the cycle in which start is presented, where L is the effective length.
- R7: A start presented while `busy_o` is high is ignored. It produces no branch pulse and does not alter the operation in flight.
- R8: After reset the unit is idle with `busy_o`, `rd_en_o`, `wr_en_o` and `branch_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| src_a_base_i | input | 5 | First source base register |
| src_a_vec_i | input | 1 | First source is vectorised |
| src_b_base_i | input | 5 | Second source base register |
| src_b_vec_i | input | 1 | Second source is vectorised |
| cmp_op_i | input | 3 | Comparison code |
| vec_len_i | input | 6 | Vector length (values above 32 clamp to 32) |
| mask_dst_i | input | 5 | Target predicate register |
| rd_en_o | output | 1 | Register read request |
| rd_a_addr_o | output | 5 | Read port A address |
| rd_b_addr_o | output | 5 | Read port B address |
| rd_a_data_i | input | 32 | Port A data, valid the cycle after the request |
| rd_b_data_i | input | 32 | Port B data, valid the cycle after the request |
| wr_en_o | output | 1 | Predicate write strobe |
| wr_addr_o | output | 5 | Predicate write address |
| wr_data_o | output | 32 | Merged predicate mask |
| branch_o | output | 1 | Take a normal branch |
| busy_o | output | 1 | Loop in progress |

## Verification
A corrupted state or element counter shows first as a write strobe arriving earlier or later than L+3 cycles, or as read addresses outside the expected walk. Both are visible within the same operation. A wrongly latched operand or comparison code shows only at the single write, as mask bits that disagree with the reference relation over the register contents. Losing the prior-value capture shows as cleared bits above the vector length at that same write. A broken idle decode shows within one cycle, as a branch pulse during a vector operation or a missing pulse on an all-scalar start.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    // comparison codes
    localparam logic [2:0] CMP_EQ  = 3'b000;
    localparam logic [2:0] CMP_NE  = 3'b001;
    localparam logic [2:0] CMP_LT  = 3'b100;
    localparam logic [2:0] CMP_GE  = 3'b101;
    localparam logic [2:0] CMP_LTU = 3'b110;
    localparam logic [2:0] CMP_GEU = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MASK_RD = 3'd1,
        ST_ELEM_RD = 3'd2,
        ST_FLUSH   = 3'd3,
        ST_WRITE   = 3'd4
    } vcmp_state_e;

endpackage

// File: rtl/vcmp_compare.sv
module vcmp_compare
    import vcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output logic              hit_o
);

    logic eq_w;
    logic slt_w;
    logic ult_w;

    assign eq_w  = (lhs_i == rhs_i);
    assign slt_w = ($signed(lhs_i) < $signed(rhs_i));
    assign ult_w = (lhs_i < rhs_i);

    always_comb begin
        unique case (op_i)
            CMP_EQ:  hit_o = eq_w;
            CMP_NE:  hit_o = !eq_w;
            CMP_LT:  hit_o = slt_w;
            CMP_GE:  hit_o = !slt_w;
            CMP_LTU: hit_o = ult_w;
            CMP_GEU: hit_o = !ult_w;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcmp_elem_addr.sv
module vcmp_elem_addr #(
    parameter int REG_AW = 5,
    parameter int IDX_W  = 5
) (
    input  logic [REG_AW-1:0] base_i,
    input  logic              vec_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [REG_AW-1:0] addr_o
);

    // register number wraps around the register file
    assign addr_o = vec_i ? (base_i + REG_AW'(idx_i)) : base_i;

endmodule

// File: rtl/vcmp_mask_acc.sv
module vcmp_mask_acc #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              set_en_i,
    input  logic [IDX_W-1:0]  set_idx_i,
    output logic [DATA_W-1:0] mask_o
);

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[g] <= 1'b0;
            end else if (load_en_i) begin
                mask_o[g] <= load_val_i[g];
            end else if (set_en_i && (set_idx_i == IDX_W'(g))) begin
                mask_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
    import vcmp_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  REG_AW = 5,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int VL_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_AW-1:0] src_a_base_i,
    input  logic              src_a_vec_i,
    input  logic [REG_AW-1:0] src_b_base_i,
    input  logic              src_b_vec_i,
    input  logic [2:0]        cmp_op_i,
    input  logic [VL_W-1:0]   vec_len_i,
    input  logic [REG_AW-1:0] mask_dst_i,
    output logic              rd_en_o,
    output logic [REG_AW-1:0] rd_a_addr_o,
    output logic [REG_AW-1:0] rd_b_addr_o,
    input  logic [DATA_W-1:0] rd_a_data_i,
    input  logic [DATA_W-1:0] rd_b_data_i,
    output logic              wr_en_o,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              branch_o,
    output logic              busy_o
);

    localparam int          NSRC   = 2;
    localparam logic [VL_W-1:0] MAX_VL = VL_W'(DATA_W);

    vcmp_state_e state_q, state_d;

    logic [REG_AW-1:0] base_q [NSRC];
    logic              vec_q  [NSRC];
    logic [REG_AW-1:0] addr_w [NSRC];
    logic [REG_AW-1:0] dst_q;
    logic [2:0]        op_q;
    logic [VL_W-1:0]   vl_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pend_mask_q;
    logic              pend_elem_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic              branch_q;

    logic              accept_w;
    logic              all_scalar_w;
    logic              launch_w;
    logic [VL_W-1:0]   vl_eff_w;
    logic              idx_last_w;
    logic              hit_w;
    logic [DATA_W-1:0] mask_w;

    assign accept_w     = start_i && (state_q == ST_IDLE);
    assign all_scalar_w = !src_a_vec_i && !src_b_vec_i;
    assign launch_w     = accept_w && !all_scalar_w;
    assign vl_eff_w     = (vec_len_i > MAX_VL) ? MAX_VL : vec_len_i;
    assign idx_last_w   = ({1'b0, idx_q} == (vl_q - VL_W'(1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_w) begin
                    state_d = ST_MASK_RD;
                end
            end
            ST_MASK_RD: begin
                state_d = (vl_q == '0) ? ST_FLUSH : ST_ELEM_RD;
            end
            ST_ELEM_RD: begin
                if (idx_last_w) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // operand latch and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q <= '0;
            op_q  <= '0;
            vl_q  <= '0;
            idx_q <= '0;
            for (int s = 0; s < NSRC; s++) begin
                base_q[s] <= '0;
                vec_q[s]  <= 1'b0;
            end
        end else if (launch_w) begin
            base_q[0] <= src_a_base_i;
            vec_q[0]  <= src_a_vec_i;
            base_q[1] <= src_b_base_i;
            vec_q[1]  <= src_b_vec_i;
            dst_q     <= mask_dst_i;
            op_q      <= cmp_op_i;
            vl_q      <= vl_eff_w;
            idx_q     <= '0;
        end else if (state_q == ST_ELEM_RD) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // response tracking: which read is answered this cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_mask_q <= 1'b0;
            pend_elem_q <= 1'b0;
            pend_idx_q  <= '0;
            branch_q    <= 1'b0;
        end else begin
            pend_mask_q <= (state_q == ST_MASK_RD);
            pend_elem_q <= (state_q == ST_ELEM_RD);
            pend_idx_q  <= idx_q;
            branch_q    <= accept_w && all_scalar_w;
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        vcmp_elem_addr #(
            .REG_AW (REG_AW),
            .IDX_W  (IDX_W)
        ) u_addr (
            .base_i (base_q[s]),
            .vec_i  (vec_q[s]),
            .idx_i  (idx_q),
            .addr_o (addr_w[s])
        );
    end

    vcmp_compare #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .op_i  (op_q),
        .lhs_i (rd_a_data_i),
        .rhs_i (rd_b_data_i),
        .hit_o (hit_w)
    );

    vcmp_mask_acc #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en_i  (pend_mask_q),
        .load_val_i (rd_a_data_i),
        .set_en_i   (pend_elem_q && hit_w),
        .set_idx_i  (pend_idx_q),
        .mask_o     (mask_w)
    );

    // outputs
    always_comb begin
        rd_en_o     = 1'b0;
        rd_a_addr_o = addr_w[0];
        rd_b_addr_o = addr_w[1];
        wr_en_o     = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_MASK_RD: begin
                rd_en_o     = 1'b1;
                rd_a_addr_o = dst_q;
            end
            ST_ELEM_RD: begin
                rd_en_o = 1'b1;
            end
            ST_FLUSH: begin
                rd_en_o = 1'b0;
            end
            ST_WRITE: begin
                wr_en_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign wr_addr_o = dst_q;
    assign wr_data_o = mask_w;
    assign branch_o  = branch_q;

endmodule

// File: rtl/vcmp_mask_unit_chk.sv
module vcmp_mask_unit_chk
    import vcmp_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  REG_AW = 5,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int VL_W   = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              src_a_vec_i,
    input logic              src_b_vec_i,
    input logic [VL_W-1:0]   vec_len_i,
    input logic [REG_AW-1:0] mask_dst_i,
    input logic              rd_en_o,
    input logic [REG_AW-1:0] rd_a_addr_o,
    input logic [DATA_W-1:0] rd_a_data_i,
    input logic              wr_en_o,
    input logic [REG_AW-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              branch_o,
    input logic              busy_o,
    input vcmp_state_e       state_q
);

    logic              take_w;
    logic [REG_AW-1:0] dst_cap;
    logic [VL_W-1:0]   vl_cap;
    logic              prior_due;
    logic [DATA_W-1:0] prior_cap;
    logic [DATA_W-1:0] low_mask;

    assign take_w = start_i && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_cap   <= '0;
            vl_cap    <= '0;
            prior_due <= 1'b0;
            prior_cap <= '0;
        end else begin
            if (take_w && (src_a_vec_i || src_b_vec_i)) begin
                dst_cap <= mask_dst_i;
                vl_cap  <= (vec_len_i > VL_W'(DATA_W)) ? VL_W'(DATA_W) : vec_len_i;
            end
            prior_due <= rd_en_o && (state_q == ST_MASK_RD);
            if (prior_due) begin
                prior_cap <= rd_a_data_i;
            end
        end
    end

    always_comb begin
        if (vl_cap >= VL_W'(DATA_W)) begin
            low_mask = '1;
        end else begin
            low_mask = (DATA_W'(1) << vl_cap) - DATA_W'(1);
        end
    end

    assert_branch_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_w && !src_a_vec_i && !src_b_vec_i |=> branch_o);

    assert_branch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> !busy_o && !rd_en_o && !wr_en_o);

    assert_prior_read_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MASK_RD |-> rd_en_o && (rd_a_addr_o == dst_cap));

    assert_prior_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_data_o & prior_cap) == prior_cap));

    assert_upper_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_data_o & ~prior_cap & ~low_mask) == '0));

    assert_write_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o == dst_cap));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> !branch_o);

endmodule

bind vcmp_mask_unit vcmp_mask_unit_chk #(
    .DATA_W (DATA_W),
    .REG_AW (REG_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .src_a_vec_i (src_a_vec_i),
    .src_b_vec_i (src_b_vec_i),
    .vec_len_i   (vec_len_i),
    .mask_dst_i  (mask_dst_i),
    .rd_en_o     (rd_en_o),
    .rd_a_addr_o (rd_a_addr_o),
    .rd_a_data_i (rd_a_data_i),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .branch_o    (branch_o),
    .busy_o      (busy_o),
    .state_q     (state_q)
);

// File: tb/vcmp_mask_unit_bench.sv
module vcmp_mask_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  src_a_base_i = '0;
    logic        src_a_vec_i = 1'b0;
    logic [4:0]  src_b_base_i = '0;
    logic        src_b_vec_i = 1'b0;
    logic [2:0]  cmp_op_i = '0;
    logic [5:0]  vec_len_i = '0;
    logic [4:0]  mask_dst_i = '0;
    logic        rd_en_o;
    logic [4:0]  rd_a_addr_o;
    logic [4:0]  rd_b_addr_o;
    logic [31:0] rd_a_data_i = '0;
    logic [31:0] rd_b_data_i = '0;
    logic        wr_en_o;
    logic [4:0]  wr_addr_o;
    logic [31:0] wr_data_o;
    logic        branch_o;
    logic        busy_o;

    logic [31:0] rf [32];
    int          n_checks = 0;
    int          n_fails  = 0;
    int          cyc      = 0;

    always #2 clk = ~clk;   // 250 MHz

    vcmp_mask_unit u_vcmp_mask_unit (
        .clk, .rst_n, .start_i, .src_a_base_i, .src_a_vec_i, .src_b_base_i,
        .src_b_vec_i, .cmp_op_i, .vec_len_i, .mask_dst_i, .rd_en_o,
        .rd_a_addr_o, .rd_b_addr_o, .rd_a_data_i, .rd_b_data_i, .wr_en_o,
        .wr_addr_o, .wr_data_o, .branch_o, .busy_o
    );

    // register file model with single-cycle read
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en_o) begin
            rd_a_data_i <= rf[rd_a_addr_o];
            rd_b_data_i <= rf[rd_b_addr_o];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic ref_rel(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'b000: return a == b;
            3'b001: return a != b;
            3'b100: return $signed(a) < $signed(b);
            3'b101: return $signed(a) >= $signed(b);
            3'b110: return a < b;
            3'b111: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_mask(input logic [4:0] ab, input logic av, input logic [4:0] bb,
                                             input logic bv, input logic [2:0] op, input int vl,
                                             input logic [4:0] dst);
        logic [31:0] m = rf[dst];
        for (int i = 0; i < vl; i++) begin
            logic [4:0] ea = av ? 5'(ab + 5'(i)) : ab;
            logic [4:0] eb = bv ? 5'(bb + 5'(i)) : bb;
            if (ref_rel(op, rf[ea], rf[eb])) m[i] = 1'b1;
        end
        return m;
    endfunction

    // run one vector operation; poke > 0 injects a scalar start at that cycle
    task automatic run_vec(input string req, input logic [4:0] ab, input logic av, input logic [4:0] bb,
                           input logic bv, input logic [2:0] op, input int len, input logic [4:0] dst,
                           input int poke);
        int          vl = (len > 32) ? 32 : len;
        logic [31:0] exp = ref_mask(ab, av, bb, bv, op, vl, dst);
        int          seen_at = -1;
        logic [4:0]  seen_addr = '0;
        logic [31:0] seen_data = '0;
        logic        saw_branch = 1'b0;
        @(negedge clk);
        src_a_base_i = ab; src_a_vec_i = av;
        src_b_base_i = bb; src_b_vec_i = bv;
        cmp_op_i = op; vec_len_i = 6'(len); mask_dst_i = dst;
        start_i = 1'b1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (branch_o) saw_branch = 1'b1;
            if (wr_en_o && seen_at < 0) begin
                seen_at = k; seen_addr = wr_addr_o; seen_data = wr_data_o;
            end
            start_i = 1'b0;
            if (k == poke) begin
                start_i = 1'b1; src_a_vec_i = 1'b0; src_b_vec_i = 1'b0;
                mask_dst_i = 5'd0; cmp_op_i = 3'b000; vec_len_i = 6'd1;
            end
        end
        chk(req, "mask value (R4)", seen_data, exp);
        chk("R6", "write latency", 32'(seen_at), 32'(vl + 3));
        chk("R6", "write address", 32'(seen_addr), 32'(dst));
        chk("R1", "branch during vector op", 32'(saw_branch), 32'd0);
    endtask

    task automatic test_reset;
        @(negedge clk);
        chk("R8", "busy after reset", 32'(busy_o), 0);
        chk("R8", "rd_en after reset", 32'(rd_en_o), 0);
        chk("R8", "wr_en after reset", 32'(wr_en_o), 0);
        chk("R8", "branch after reset", 32'(branch_o), 0);
    endtask

    task automatic test_scalar_branch;
        logic any_rd = 1'b0;
        logic any_wr = 1'b0;
        @(negedge clk);
        src_a_base_i = 5'd3; src_a_vec_i = 1'b0;
        src_b_base_i = 5'd4; src_b_vec_i = 1'b0;
        cmp_op_i = 3'b001; vec_len_i = 6'd8; mask_dst_i = 5'd30;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1", "branch pulse", 32'(branch_o), 1);
        chk("R1", "busy on scalar start", 32'(busy_o), 0);
        for (int k = 0; k < 6; k++) begin
            if (rd_en_o) any_rd = 1'b1;
            if (wr_en_o) any_wr = 1'b1;
            @(negedge clk);
        end
        chk("R1", "branch pulse width", 32'(branch_o), 0);
        chk("R1", "reads on scalar start", 32'(any_rd), 0);
        chk("R1", "write on scalar start", 32'(any_wr), 0);
    endtask

    task automatic test_all_codes;
        logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
        foreach (codes[c]) run_vec("R3", 5'd2, 1'b1, 5'd18, 1'b1, codes[c], 10, 5'd30, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            case (i % 3)
                0: rf[i] = 32'hFFFF_FF00 + 32'(i * 5);
                1: rf[i] = 32'(i * 7);
                default: rf[i] = 32'h8000_0000 ^ 32'(i * 3);
            endcase
        end
        for (int i = 0; i < 4; i++) rf[20 + i] = rf[4 + i];   // equal pairs
        rf[30] = 32'h4000_0002;   // prior predicate with bits inside and above length
        rf[31] = 32'hA5A5_0000;
        rf[29] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_scalar_branch();
        test_all_codes();
        run_vec("R2", 5'd5, 1'b0, 5'd10, 1'b1, 3'b110, 12, 5'd29, 0);   // scalar vs vector
        run_vec("R2", 5'd7, 1'b1, 5'd6, 1'b0, 3'b101, 9, 5'd31, 0);     // vector vs scalar
        run_vec("R3", 5'd2, 1'b1, 5'd18, 1'b1, 3'b010, 10, 5'd31, 0);   // undefined code
        run_vec("R5", 5'd1, 1'b1, 5'd2, 1'b1, 3'b001, 0, 5'd31, 0);     // zero length
        run_vec("R5", 5'd20, 1'b1, 5'd4, 1'b1, 3'b000, 40, 5'd30, 0);   // clamp and wrap
        run_vec("R7", 5'd2, 1'b1, 5'd18, 1'b1, 3'b100, 10, 5'd29, 2);   // start while busy
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait (cyc == 100000);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: run got %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule